// File: doc/BRIEF.md
# Display Clock Prescaler and Refresh Timer

This block produces the display-clock enable and the refresh-frame timing for a dot-matrix display driver. Everything runs on one system clock. The two oscillators arrive as one-cycle enable pulses: an internal one and an external one. A source select picks which of the two drives the display. On the external path a prescale bit can slow the display clock to one tick for every eight oscillator ticks. On the internal path that bit has no effect.

Each display tick advances a 9-bit refresh position. One full refresh takes 512 display ticks. When the position wraps back to zero, the block raises a one-cycle end-of-frame pulse. The selected raw oscillator pulse is also driven out undivided. A master chip can therefore pace slave chips, whose external oscillator inputs are tied to that output.

Top module: `disp_clk_timer`

## Requirements
- R1: With `use_ext`=1 and `prescale`=0, each cycle with `ext_tick` high produces `disp_en` high in the next cycle. `disp_en` is never high unless the selected oscillator pulse was high in the cycle before.
- R2: With `use_ext`=1 and `prescale`=1, `disp_en` pulses once for every 8 `ext_tick` pulses. It pulses in the cycle after the 8th pulse.
- R3: `pos` advances by exactly one in the cycle that `disp_en` is high and otherwise holds. It wraps from 511 to 0, so 512 display ticks (4096 external pulses when prescaled) bring it back to its starting value.
- R4: With `use_ext`=0, every `int_tick` pulse produces `disp_en` in the next cycle whatever the value of `prescale`. `ext_tick` pulses have no effect on `disp_en` or `pos` in this mode.
- R5: `frame_end` is high for exactly one cycle, together with `disp_en`, in the cycle that `pos` has just wrapped to 0.
- R6: `osc_out` equals `ext_tick` when `use_ext`=1 and `int_tick` when `use_ext`=0, in the same cycle and undivided.
- R7: Reset (`rst_n` low, asynchronous) clears `pos`, `disp_en`, `frame_end` and the divide-by-8 count together. After reset, the first prescaled display tick follows the 8th external pulse.
- R8: The divide-by-8 count is held at zero whenever `prescale` is 0 or the internal source is selected. After `prescale` is set again, or the external source is reselected, the first display tick comes only on the 8th external pulse, so no shortened tick occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick | input | 1 | External oscillator enable pulse |
| int_tick | input | 1 | Internal oscillator enable pulse |
| use_ext | input | 1 | 1 selects the external oscillator, 0 the internal |
| prescale | input | 1 | 1 divides the external oscillator by 8 |
| osc_out | output | 1 | Selected raw oscillator pulse for slave chips |
| disp_en | output | 1 | Display-clock enable, one cycle per display tick |
| pos | output | 9 | Refresh position, 0 to 511 |
| frame_end | output | 1 | One-cycle pulse when the refresh position wraps to 0 |

## Verification
Several properties are checked on every cycle:
- each display tick follows a tick of the selected source,
- the direct and internal paths respond in the very next cycle,
- the divided path fires only after a count of eight,
- the position steps by one or holds,
- end-of-frame appears only together with a wrap to zero.

Some behaviour only the bench scenarios can show. These are the long-run totals: full frames of 512 and 4096 ticks, and the position and frame counts after mixed pulse patterns. The other bench-only cases are the restart of the divider after prescale toggles, source switches and a reset in mid-count, and the reset values themselves.

// File: rtl/disp_clk_timer.sv
module disp_clk_timer #(
  parameter int DIV   = 8,
  parameter int FRAME = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ext_tick,
  input  logic                     int_tick,
  input  logic                     use_ext,
  input  logic                     prescale,
  output logic                     osc_out,
  output logic                     disp_en,
  output logic [$clog2(FRAME)-1:0] pos,
  output logic                     frame_end
);
  localparam int DW = $clog2(DIV);
  localparam int PW = $clog2(FRAME);

  logic [DW-1:0] div_q;

  wire src_tick = use_ext ? ext_tick : int_tick;
  wire div_on   = use_ext & prescale;
  wire div_last = (div_q == DW'(DIV - 1));
  wire fire     = src_tick & (~div_on | div_last);
  wire wrap     = (pos == PW'(FRAME - 1));

  assign osc_out = src_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (!div_on)  div_q <= '0;
    else if (ext_tick) div_q <= div_last ? '0 : div_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_en   <= 1'b0;
      frame_end <= 1'b0;
      pos       <= '0;
    end else begin
      disp_en   <= fire;
      frame_end <= fire & wrap;
      if (fire) pos <= wrap ? '0 : pos + PW'(1);
    end
  end
endmodule

// File: rtl/disp_clk_timer_chk.sv
module disp_clk_timer_chk #(
  parameter int DIV   = 8,
  parameter int FRAME = 512
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ext_tick,
  input logic                     int_tick,
  input logic                     use_ext,
  input logic                     prescale,
  input logic                     osc_out,
  input logic                     disp_en,
  input logic [$clog2(FRAME)-1:0] pos,
  input logic                     frame_end
);
  localparam int DW = $clog2(DIV);
  localparam int PW = $clog2(FRAME);

  logic [DW-1:0] ck_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ck_cnt <= '0;
    else if (!(use_ext && prescale)) ck_cnt <= '0;
    else if (ext_tick)             ck_cnt <= (ck_cnt == DW'(DIV - 1)) ? '0 : ck_cnt + DW'(1);
  end

  p_ext_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ext && !prescale && ext_tick) |=> disp_en);
  p_no_stray_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(use_ext ? ext_tick : int_tick) |=> !disp_en);
  p_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ext && prescale && ext_tick) |=> (disp_en == ($past(ck_cnt) == DW'(DIV - 1))));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && $past(pos) != PW'(FRAME - 1)) |-> pos == $past(pos) + PW'(1));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && $past(pos) == PW'(FRAME - 1)) |-> pos == '0);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> $stable(pos));
  p_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_ext && int_tick) |=> disp_en);
  p_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (disp_en && pos == '0));
endmodule

bind disp_clk_timer disp_clk_timer_chk #(.DIV(DIV), .FRAME(FRAME)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .int_tick(int_tick),
  .use_ext(use_ext), .prescale(prescale), .osc_out(osc_out),
  .disp_en(disp_en), .pos(pos), .frame_end(frame_end)
);

// File: tb/disp_clk_timer_test.sv
`timescale 1ns/1ps
module disp_clk_timer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_tick = 1'b0, int_tick = 1'b0, use_ext = 1'b0, prescale = 1'b0;
  logic osc_out, disp_en, frame_end;
  logic [8:0] pos;

  int total = 0, bad = 0;
  int en_cnt = 0, fe_cnt = 0, fe_bad = 0, osc_bad = 0;
  logic fe_prev = 1'b0;
  int e0, f0, p0;

  always #5 clk = ~clk;

  disp_clk_timer uut (
    .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .int_tick(int_tick),
    .use_ext(use_ext), .prescale(prescale), .osc_out(osc_out),
    .disp_en(disp_en), .pos(pos), .frame_end(frame_end)
  );

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (disp_en) en_cnt++;
      if (frame_end) begin
        fe_cnt++;
        if (pos != 9'd0 || !disp_en) fe_bad++;
      end
      if (frame_end && fe_prev) fe_bad++;
      if (osc_out !== (use_ext ? ext_tick : int_tick)) osc_bad++;
    end
    fe_prev = frame_end;
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic e, input logic i, input int gap);
    @(negedge clk);
    ext_tick = e; int_tick = i;
    @(negedge clk);
    ext_tick = 1'b0; int_tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic mark();
    e0 = en_cnt; f0 = fe_cnt; p0 = int'(pos);
  endtask

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset pos", int'(pos), 0);
    check("R7 reset disp_en", int'(disp_en), 0);
    check("R7 reset frame_end", int'(frame_end), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 internal, prescale low, back-to-back ticks
    mark();
    for (int k = 0; k < 600; k++) pulse(1'b0, 1'b1, 0);
    check("R4 internal ticks", en_cnt - e0, 600);
    check("R3 pos after 600", int'(pos), 600 % 512);
    check("R5 frames after 600", fe_cnt - f0, 1);

    // R4 internal with prescale high; ext pulses ignored
    prescale = 1'b1;
    mark();
    for (int k = 0; k < 200; k++) pulse(1'b1, 1'b1, 1);
    for (int k = 0; k < 50; k++) pulse(1'b1, 1'b0, k % 2);
    check("R4 prescale ignored", en_cnt - e0, 200);
    check("R4 pos", int'(pos), (p0 + 200) % 512);

    // R1 external direct, irregular gaps, int pulses ignored
    use_ext = 1'b1; prescale = 1'b0;
    mark();
    for (int k = 0; k < 300; k++) pulse(1'b1, logic'(k % 2), k % 3);
    for (int k = 0; k < 40; k++) pulse(1'b0, 1'b1, 0);
    check("R1 external direct", en_cnt - e0, 300);
    check("R3 pos direct", int'(pos), (p0 + 300) % 512);
    check("R5 frames direct", fe_cnt - f0, (p0 + 300) / 512);

    // R2/R3 full prescaled frame
    prescale = 1'b1;
    mark();
    for (int k = 0; k < 4096; k++) pulse(1'b1, 1'b0, 0);
    check("R2 ticks per 4096", en_cnt - e0, 512);
    check("R3 pos after frame", int'(pos), p0);
    check("R5 one frame", fe_cnt - f0, 1);

    // R8 restart after prescale toggle
    mark();
    for (int k = 0; k < 5; k++) pulse(1'b1, 1'b0, 0);
    check("R8 partial count", en_cnt - e0, 0);
    prescale = 1'b0; @(negedge clk);
    prescale = 1'b1; @(negedge clk);
    for (int k = 0; k < 7; k++) pulse(1'b1, 1'b0, 0);
    check("R8 no short tick", en_cnt - e0, 0);
    pulse(1'b1, 1'b0, 0);
    check("R8 eighth tick", en_cnt - e0, 1);

    // R8 restart after source switch
    for (int k = 0; k < 3; k++) pulse(1'b1, 1'b0, 0);
    use_ext = 1'b0; @(negedge clk);
    use_ext = 1'b1; @(negedge clk);
    for (int k = 0; k < 7; k++) pulse(1'b1, 1'b0, 0);
    check("R8 switch no short", en_cnt - e0, 1);
    pulse(1'b1, 1'b0, 0);
    check("R8 switch eighth", en_cnt - e0, 2);
    check("R3 pos after restarts", int'(pos), (p0 + 2) % 512);

    // R7 reset mid-count
    for (int k = 0; k < 3; k++) pulse(1'b1, 1'b0, 0);
    rst_n = 1'b0; @(negedge clk);
    check("R7 mid reset pos", int'(pos), 0);
    rst_n = 1'b1; @(negedge clk);
    mark();
    for (int k = 0; k < 7; k++) pulse(1'b1, 1'b0, 0);
    check("R7 divider cleared", en_cnt - e0, 0);
    pulse(1'b1, 1'b0, 0);
    check("R7 first tick", en_cnt - e0, 1);
    check("R7 pos one", int'(pos), 1);

    // R6 slave output follows selected source
    @(negedge clk);
    use_ext = 1'b0; int_tick = 1'b1; ext_tick = 1'b0; #1;
    check("R6 internal out", int'(osc_out), 1);
    use_ext = 1'b1; #1;
    check("R6 external out", int'(osc_out), 0);
    @(negedge clk);
    ext_tick = 1'b1; int_tick = 1'b0; #1;
    check("R6 undivided out", int'(osc_out), 1);
    @(negedge clk);
    ext_tick = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 osc mismatches", osc_bad, 0);
    check("R5 frame pulse shape", fe_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule